// File: doc/BRIEF.md
# Display Path Flush Control Registers

This block is the register-level control point of one display composition path. Software builds up a set of pending double-buffer update requests for the units of the path: source pipes, blend mixers, post-processing units, 3D-merge units and output interfaces. It then commits them through a small register file. The requests are held until the next frame boundary. At that boundary the block emits a one-cycle update strobe for every requested unit and empties its pending state, so the units swap their shadow settings at the same frame.

The flush has two levels. The main flush word carries one bit per pipe, mixer and post-processor. Two of its bits are summary bits, and they decide whether the separate per-instance sub-masks for the 3D-merge units and the interfaces are applied. The block also holds a start trigger, a prepare trigger, an interface-active set, a single-entry 3D-merge active selection and a mode register. A self-clearing software reset holds the path in reset for a fixed number of clock cycles and reports busy while it runs. A simple valid/ready register port takes the place of the host bus. It always accepts a request and returns read data one cycle later.

Top module: `dpath_flush_ctrl`

## Requirements
- R1: After the synchronous active-low reset, the flush word, both sub-masks, start, both active registers and all strobes are zero, the mode register (byte 0x014) reads 0xF000_0000 and the path is not in software reset.
- R2: A write to the flush word (byte 0x018) ORs the written bits into the pending word, which reads back at 0x018. No update strobe appears before a frame boundary.
- R3: When frame_tick_i is high at a clock edge, upd_main_o equals the pending flush word for exactly the following cycle. At that edge the flush word and both sub-masks are cleared.
- R4: Writing any mixer bit of the flush word (bits 6, 7, 8, 9, 10 or 20) also sets the control-path bit 17 of the pending word.
- R5: Writes to the 3D-merge sub-mask (byte 0x100, bit n = merge unit n) and the interface sub-mask (byte 0x110, bit n = interface n) OR into those masks. At a frame boundary upd_merge_o carries that mask only if flush bit 23 is set, and upd_intf_o carries its mask only if flush bit 31 is set.
- R6: A sub-mask whose summary bit is clear at a frame boundary produces no strobe and is discarded. A later frame with the summary bit set then carries an empty mask.
- R7: Writing 1 to bit 0 of the start register (byte 0x01C) sets the started flag, which reads back in bit 0 and drives path_start_o. Writing 0 leaves it unchanged.
- R8: Writing 1 to bit 0 of the prepare register (byte 0x0D0) gives a single-cycle pulse on prep_o in the cycle after the write. The register reads 0.
- R9: Writing an index n below NUM_INTF to the interface-active register (byte 0x0F4) sets bit n and keeps the bits already set. A larger index leaves the register unchanged.
- R10: Writing an index n below NUM_MERGE to the 3D-merge active register (byte 0x0E4) replaces its content with only bit n set. A larger index leaves it unchanged.
- R11: The mode register keeps bit 17 (1 = command mode, 0 = video mode) and bits 31:28 (group ID). Its other bits read 0. cmd_mode_o and group_id_o follow the stored fields.
- R12: Writing 1 to bit 0 of the software-reset register (byte 0x030) holds path_reset_o high for exactly RST_CYCLES cycles, starting in the cycle after the write. Bit 0 of that register reads 1 while the reset runs.
- R13: While the software reset runs, the flush word, sub-masks, start flag and both active registers are held at zero, and writes to them are ignored. The mode register keeps its value.
- R14: req_ready_o is always 1. rsp_valid_o pulses in the cycle after each accepted read. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Register access request valid |
| req_ready_o | output | 1 | Request accepted (always 1) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte address of the register |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata_o | output | 32 | Read data |
| frame_tick_i | input | 1 | Frame boundary pulse |
| upd_main_o | output | 32 | Per-unit update strobes from the flush word |
| upd_merge_o | output | NUM_MERGE | Per-instance 3D-merge update strobes |
| upd_intf_o | output | NUM_INTF | Per-instance interface update strobes |
| path_start_o | output | 1 | Path started flag |
| prep_o | output | 1 | Prepare trigger pulse |
| path_reset_o | output | 1 | Software reset in progress |
| cmd_mode_o | output | 1 | Command mode selected |
| group_id_o | output | 4 | Group ID field |
| intf_active_o | output | NUM_INTF | Active interface set |
| merge_active_o | output | NUM_MERGE | Active 3D-merge unit |

## Verification
If the pending flush state goes wrong inside the block, it shows up as a read-back mismatch at byte 0x018 in the next read. At the latest it shows up as a wrong strobe pattern in the single cycle after the next frame tick. Because the summary bits gate the sub-masks, a leaked or stale sub-mask only becomes visible when a frame with the summary bit set follows. The bench therefore runs a frame without the summary bit, then a frame with it. A reset counter that is off by one shows up directly as a path_reset_o pulse of the wrong length. A write gate that fails during busy shows up as a non-zero register once the reset ends.

// File: rtl/dpf_pkg.sv
// Package: shared constants for the display path flush controller.
// Assumes a 12-bit byte address space and a 32-bit register width.
package dpf_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_MODE      = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_FLUSH     = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_START     = 12'h01C;
    localparam logic [ADDR_W-1:0] OFS_SWRST     = 12'h030;
    localparam logic [ADDR_W-1:0] OFS_PREP      = 12'h0D0;
    localparam logic [ADDR_W-1:0] OFS_MRG_ACT   = 12'h0E4;
    localparam logic [ADDR_W-1:0] OFS_INTF_ACT  = 12'h0F4;
    localparam logic [ADDR_W-1:0] OFS_MRG_FLUSH = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_INTF_FLUSH= 12'h110;

    localparam int BIT_CTL_PATH  = 17;
    localparam int BIT_MRG_SUM   = 23;
    localparam int BIT_INTF_SUM  = 31;
    localparam int BIT_CMD_MODE  = 17;

    localparam logic [DATA_W-1:0] MIXER_BITS = 32'h0010_07C0;
    localparam logic [3:0]        GROUP_DFLT = 4'hF;
endpackage

// File: rtl/dpf_soft_reset.sv
// Module: self-clearing software reset sequencer.
// A request starts a countdown of RST_CYCLES; busy is high for exactly
// that many cycles. Requests that arrive while busy are ignored.
module dpf_soft_reset #(
    parameter int RST_CYCLES = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic busy_o
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Load the countdown on a request when idle, count down while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else if (req_i) begin
            cnt_q <= CNT_LOAD;
        end
    end

    assign busy_o = (cnt_q != '0);

    p_busy_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LOAD);

    p_busy_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !busy_o) |=> (busy_o && cnt_q == CNT_LOAD));
endmodule

// File: rtl/dpf_flush_bank.sv
// Module: two-level pending flush state and frame-boundary strobes.
// The main word accumulates writes; summary bits gate the sub-masks at
// the frame. Assumes writes are already blocked upstream during reset.
module dpf_flush_bank
    import dpf_pkg::*;
#(
    parameter int NUM_MERGE = 4,
    parameter int NUM_INTF  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 busy_i,
    input  logic                 frame_i,
    input  logic                 main_wr_i,
    input  logic                 merge_wr_i,
    input  logic                 intf_wr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    main_q_o,
    output logic [NUM_MERGE-1:0] merge_q_o,
    output logic [NUM_INTF-1:0]  intf_q_o,
    output logic [DATA_W-1:0]    upd_main_o,
    output logic [NUM_MERGE-1:0] upd_merge_o,
    output logic [NUM_INTF-1:0]  upd_intf_o
);
    logic [DATA_W-1:0]    main_q, main_add;
    logic [NUM_MERGE-1:0] merge_q;
    logic [NUM_INTF-1:0]  intf_q;

    // Extend mixer bits with the control-path bit.
    always_comb begin
        main_add = wdata_i;
        if ((wdata_i & MIXER_BITS) != '0) main_add[BIT_CTL_PATH] = 1'b1;
    end

    // Pending state: clear on reset busy or frame, then OR in new writes.
    always_ff @(posedge clk) begin
        if (!rst_n || busy_i) begin
            main_q  <= '0;
            merge_q <= '0;
            intf_q  <= '0;
        end else begin
            main_q  <= (frame_i ? '0 : main_q)  | (main_wr_i  ? main_add : '0);
            merge_q <= (frame_i ? '0 : merge_q) | (merge_wr_i ? wdata_i[NUM_MERGE-1:0] : '0);
            intf_q  <= (frame_i ? '0 : intf_q)  | (intf_wr_i  ? wdata_i[NUM_INTF-1:0]  : '0);
        end
    end

    // One-cycle update strobes issued at the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_i || busy_i) begin
            upd_main_o  <= '0;
            upd_merge_o <= '0;
            upd_intf_o  <= '0;
        end else begin
            upd_main_o  <= main_q;
            upd_merge_o <= main_q[BIT_MRG_SUM]  ? merge_q : '0;
            upd_intf_o  <= main_q[BIT_INTF_SUM] ? intf_q  : '0;
        end
    end

    assign main_q_o  = main_q;
    assign merge_q_o = merge_q;
    assign intf_q_o  = intf_q;

    p_mixer_ctl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((main_q & MIXER_BITS) != '0) |-> main_q[BIT_CTL_PATH]);

    p_merge_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_merge_o != '0) |-> upd_main_o[BIT_MRG_SUM]);

    p_intf_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_intf_o != '0) |-> upd_main_o[BIT_INTF_SUM]);

    p_frame_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && !main_wr_i && !merge_wr_i && !intf_wr_i)
        |=> (main_q == '0 && merge_q == '0 && intf_q == '0));

    p_busy_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> (main_q == '0 && merge_q == '0 && intf_q == '0));
endmodule

// File: rtl/dpf_path_cfg.sv
// Module: path configuration registers (mode, start, prepare, active sets).
// Assumes write enables are already blocked upstream while reset is busy,
// except the mode write, which is always allowed.
module dpf_path_cfg
    import dpf_pkg::*;
#(
    parameter int NUM_MERGE = 4,
    parameter int NUM_INTF  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 busy_i,
    input  logic                 mode_wr_i,
    input  logic                 start_wr_i,
    input  logic                 prep_wr_i,
    input  logic                 merge_act_wr_i,
    input  logic                 intf_act_wr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic                 cmd_mode_o,
    output logic [3:0]           group_id_o,
    output logic                 started_o,
    output logic                 prep_o,
    output logic [NUM_MERGE-1:0] merge_act_o,
    output logic [NUM_INTF-1:0]  intf_act_o
);
    logic [NUM_MERGE-1:0] merge_sel;
    logic [NUM_INTF-1:0]  intf_sel;
    logic [NUM_INTF-1:0]  intf_act_q;

    // Decode the written index into a one-hot select, zero if out of range.
    always_comb begin
        merge_sel = '0;
        intf_sel  = '0;
        for (int i = 0; i < NUM_MERGE; i++)
            if (wdata_i == DATA_W'(i)) merge_sel[i] = 1'b1;
        for (int i = 0; i < NUM_INTF; i++)
            if (wdata_i == DATA_W'(i)) intf_sel[i] = 1'b1;
    end

    // Mode register: command-mode bit and group ID; kept over soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_mode_o <= 1'b0;
            group_id_o <= GROUP_DFLT;
        end else if (mode_wr_i) begin
            cmd_mode_o <= wdata_i[BIT_CMD_MODE];
            group_id_o <= wdata_i[31:28];
        end
    end

    // Start flag, prepare pulse and active sets; cleared while reset busy.
    always_ff @(posedge clk) begin
        if (!rst_n || busy_i) begin
            started_o   <= 1'b0;
            prep_o      <= 1'b0;
            merge_act_o <= '0;
            intf_act_q  <= '0;
        end else begin
            if (start_wr_i && wdata_i[0]) started_o <= 1'b1;
            prep_o <= prep_wr_i && wdata_i[0];
            if (merge_act_wr_i && merge_sel != '0) merge_act_o <= merge_sel;
            if (intf_act_wr_i) intf_act_q <= intf_act_q | intf_sel;
        end
    end

    assign intf_act_o = intf_act_q;

    p_intf_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |=> ((intf_act_q & $past(intf_act_q)) == $past(intf_act_q)));

    p_merge_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(merge_act_o));

    p_start_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (started_o && !busy_i) |=> started_o);
endmodule

// File: rtl/dpath_flush_ctrl.sv
// Module: display path flush control register block (top).
// Decodes the valid/ready register port, gates writes during the software
// reset and returns registered read data one cycle after each read.
module dpath_flush_ctrl
    import dpf_pkg::*;
#(
    parameter int NUM_MERGE  = 4,
    parameter int NUM_INTF   = 8,
    parameter int RST_CYCLES = 1500
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid_i,
    output logic                 req_ready_o,
    input  logic                 req_write_i,
    input  logic [11:0]          req_addr_i,
    input  logic [31:0]          req_wdata_i,
    output logic                 rsp_valid_o,
    output logic [31:0]          rsp_rdata_o,
    input  logic                 frame_tick_i,
    output logic [31:0]          upd_main_o,
    output logic [NUM_MERGE-1:0] upd_merge_o,
    output logic [NUM_INTF-1:0]  upd_intf_o,
    output logic                 path_start_o,
    output logic                 prep_o,
    output logic                 path_reset_o,
    output logic                 cmd_mode_o,
    output logic [3:0]           group_id_o,
    output logic [NUM_INTF-1:0]  intf_active_o,
    output logic [NUM_MERGE-1:0] merge_active_o
);
    logic                 wr, rd, busy, wr_ok;
    logic [DATA_W-1:0]    main_q, rd_mux;
    logic [NUM_MERGE-1:0] merge_q;
    logic [NUM_INTF-1:0]  intf_q;

    assign req_ready_o = 1'b1;
    assign wr    = req_valid_i && req_write_i;
    assign rd    = req_valid_i && !req_write_i;
    assign wr_ok = wr && !busy;

    dpf_soft_reset #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (wr && req_addr_i == OFS_SWRST && req_wdata_i[0]),
        .busy_o (busy)
    );

    dpf_flush_bank #(.NUM_MERGE(NUM_MERGE), .NUM_INTF(NUM_INTF)) u_flush (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy_i      (busy),
        .frame_i     (frame_tick_i),
        .main_wr_i   (wr_ok && req_addr_i == OFS_FLUSH),
        .merge_wr_i  (wr_ok && req_addr_i == OFS_MRG_FLUSH),
        .intf_wr_i   (wr_ok && req_addr_i == OFS_INTF_FLUSH),
        .wdata_i     (req_wdata_i),
        .main_q_o    (main_q),
        .merge_q_o   (merge_q),
        .intf_q_o    (intf_q),
        .upd_main_o  (upd_main_o),
        .upd_merge_o (upd_merge_o),
        .upd_intf_o  (upd_intf_o)
    );

    dpf_path_cfg #(.NUM_MERGE(NUM_MERGE), .NUM_INTF(NUM_INTF)) u_cfg (
        .clk            (clk),
        .rst_n          (rst_n),
        .busy_i         (busy),
        .mode_wr_i      (wr && req_addr_i == OFS_MODE),
        .start_wr_i     (wr_ok && req_addr_i == OFS_START),
        .prep_wr_i      (wr_ok && req_addr_i == OFS_PREP),
        .merge_act_wr_i (wr_ok && req_addr_i == OFS_MRG_ACT),
        .intf_act_wr_i  (wr_ok && req_addr_i == OFS_INTF_ACT),
        .wdata_i        (req_wdata_i),
        .cmd_mode_o     (cmd_mode_o),
        .group_id_o     (group_id_o),
        .started_o      (path_start_o),
        .prep_o         (prep_o),
        .merge_act_o    (merge_active_o),
        .intf_act_o     (intf_active_o)
    );

    assign path_reset_o = busy;

    // Read multiplexer over all mapped registers; unmapped reads give zero.
    always_comb begin
        rd_mux = '0;
        case (req_addr_i)
            OFS_MODE:       begin
                rd_mux[31:28]        = group_id_o;
                rd_mux[BIT_CMD_MODE] = cmd_mode_o;
            end
            OFS_FLUSH:      rd_mux = main_q;
            OFS_START:      rd_mux[0] = path_start_o;
            OFS_SWRST:      rd_mux[0] = busy;
            OFS_MRG_ACT:    rd_mux[NUM_MERGE-1:0] = merge_active_o;
            OFS_INTF_ACT:   rd_mux[NUM_INTF-1:0]  = intf_active_o;
            OFS_MRG_FLUSH:  rd_mux[NUM_MERGE-1:0] = merge_q;
            OFS_INTF_FLUSH: rd_mux[NUM_INTF-1:0]  = intf_q;
            default:        rd_mux = '0;
        endcase
    end

    // Registered read response, valid one cycle after an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o <= 1'b0;
            rsp_rdata_o <= '0;
        end else begin
            rsp_valid_o <= rd;
            if (rd) rsp_rdata_o <= rd_mux;
        end
    end

    p_rsp_follows_read_r14: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(rd));

    p_reset_holds_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
        path_reset_o |=> (!path_start_o && intf_active_o == '0 && merge_active_o == '0));
endmodule

// File: tb/dpath_flush_ctrl_tb_top.sv
// Directed bench for the display path flush control registers.
module dpath_flush_ctrl_tb_top;
    localparam int NM = 4;
    localparam int NI = 8;
    localparam int RC = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [11:0]   req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          req_ready, rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          frame_tick = 1'b0;
    logic [31:0]   upd_main;
    logic [NM-1:0] upd_merge, merge_act;
    logic [NI-1:0] upd_intf, intf_act;
    logic          path_start, prep, path_reset, cmd_mode;
    logic [3:0]    group_id;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rd;

    always #10 clk = ~clk;

    dpath_flush_ctrl #(.NUM_MERGE(NM), .NUM_INTF(NI), .RST_CYCLES(RC)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
        .frame_tick_i(frame_tick),
        .upd_main_o(upd_main), .upd_merge_o(upd_merge), .upd_intf_o(upd_intf),
        .path_start_o(path_start), .prep_o(prep), .path_reset_o(path_reset),
        .cmd_mode_o(cmd_mode), .group_id_o(group_id),
        .intf_active_o(intf_act), .merge_active_o(merge_act)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check("R14 rsp_valid", {31'd0, rsp_valid}, 32'd1);
        d = rsp_rdata;
    endtask

    // Pulse the frame boundary; returns in the strobe cycle.
    task automatic frame_pulse();
        @(negedge clk);
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R1 upd_main", upd_main, 0);
        check("R1 reset busy", {31'd0, path_reset}, 0);
        bus_read(12'h018, rd); check("R1 flush", rd, 0);
        bus_read(12'h014, rd); check("R1 mode", rd, 32'hF000_0000);
        bus_read(12'h0F4, rd); check("R1 intf active", rd, 0);
        check("R14 ready", {31'd0, req_ready}, 1);
        bus_read(12'h200, rd); check("R14 unmapped", rd, 0);
    endtask

    task automatic t_accumulate_and_frame();
        bus_write(12'h018, 32'h0000_0001);
        bus_write(12'h018, 32'h0000_0800);
        bus_read(12'h018, rd); check("R2 accumulate", rd, 32'h801);
        check("R2 no early strobe", upd_main, 0);
        frame_pulse();
        check("R3 strobe", upd_main, 32'h801);
        @(negedge clk);
        check("R3 strobe one cycle", upd_main, 0);
        bus_read(12'h018, rd); check("R3 cleared", rd, 0);
    endtask

    task automatic t_mixer_ctl();
        bus_write(12'h018, 32'h0000_0040);
        bus_read(12'h018, rd); check("R4 mixer forces ctl", rd, 32'h0002_0040);
        bus_write(12'h018, 32'h0010_0000);
        bus_read(12'h018, rd); check("R4 mixer5", rd, 32'h0012_0040);
        frame_pulse();
    endtask

    task automatic t_sub_masks();
        bus_write(12'h100, 32'h2);
        bus_write(12'h110, 32'h5);
        bus_write(12'h110, 32'h10);
        bus_write(12'h018, 32'h8080_0000);
        bus_read(12'h110, rd); check("R5 intf sub read", rd, 32'h15);
        frame_pulse();
        check("R5 merge strobe", {28'd0, upd_merge}, 32'h2);
        check("R5 intf strobe", {24'd0, upd_intf}, 32'h15);
        check("R5 main strobe", upd_main, 32'h8080_0000);
    endtask

    task automatic t_gated_sub();
        bus_write(12'h100, 32'h1);
        bus_write(12'h110, 32'h3);
        bus_write(12'h018, 32'h1);
        frame_pulse();
        check("R6 merge gated", {28'd0, upd_merge}, 0);
        check("R6 intf gated", {24'd0, upd_intf}, 0);
        check("R6 main still", upd_main, 32'h1);
        bus_write(12'h018, 32'h8080_0000);
        frame_pulse();
        check("R6 merge discarded", {28'd0, upd_merge}, 0);
        check("R6 intf discarded", {24'd0, upd_intf}, 0);
    endtask

    task automatic t_start_prep();
        bus_read(12'h01C, rd); check("R7 start idle", rd, 0);
        bus_write(12'h01C, 32'h1);
        bus_read(12'h01C, rd); check("R7 start set", rd, 1);
        bus_write(12'h01C, 32'h0);
        check("R7 start sticky", {31'd0, path_start}, 1);
        bus_write(12'h0D0, 32'h1);
        check("R8 prep pulse", {31'd0, prep}, 1);
        @(negedge clk);
        check("R8 prep one cycle", {31'd0, prep}, 0);
        bus_read(12'h0D0, rd); check("R8 prep reads 0", rd, 0);
    endtask

    task automatic t_active_mode();
        bus_write(12'h0F4, 32'd2);
        bus_write(12'h0F4, 32'd5);
        bus_write(12'h0F4, 32'd9);
        bus_read(12'h0F4, rd); check("R9 intf active", rd, 32'h24);
        bus_write(12'h0E4, 32'd1);
        bus_write(12'h0E4, 32'd3);
        bus_write(12'h0E4, 32'd7);
        bus_read(12'h0E4, rd); check("R10 merge active", rd, 32'h8);
        bus_write(12'h014, 32'h3002_FFFF);
        bus_read(12'h014, rd); check("R11 mode read", rd, 32'h3002_0000);
        check("R11 cmd mode", {31'd0, cmd_mode}, 1);
        check("R11 group", {28'd0, group_id}, 32'h3);
        bus_write(12'h014, 32'h0);
        check("R11 video mode", {31'd0, cmd_mode}, 0);
    endtask

    task automatic t_soft_reset();
        int n;
        bus_write(12'h018, 32'h1);
        bus_write(12'h014, 32'h5002_0000);
        bus_write(12'h030, 32'h1);
        n = 0;
        while (path_reset && n < 100) begin
            n++;
            @(negedge clk);
        end
        check("R12 busy length", n, RC);
        bus_read(12'h018, rd); check("R13 flush cleared", rd, 0);
        bus_read(12'h01C, rd); check("R13 start cleared", rd, 0);
        bus_read(12'h0F4, rd); check("R13 intf active cleared", rd, 0);
        bus_read(12'h014, rd); check("R13 mode kept", rd, 32'h5002_0000);
        bus_write(12'h030, 32'h1);
        bus_write(12'h018, 32'h4);
        bus_write(12'h01C, 32'h1);
        bus_read(12'h030, rd); check("R12 busy reads 1", rd, 1);
        repeat (RC + 2) @(negedge clk);
        bus_read(12'h030, rd); check("R12 busy done", rd, 0);
        bus_read(12'h018, rd); check("R13 flush write ignored", rd, 0);
        check("R13 start write ignored", {31'd0, path_start}, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_accumulate_and_frame();
        t_mixer_ctl();
        t_sub_masks();
        t_gated_sub();
        t_start_prep();
        t_active_mode();
        t_soft_reset();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule